// File: doc/BRIEF.md
# Floating-Point Compare with Condition-Code Writeback

This block compares two IEEE-754 binary floating-point operands and turns the outcome into a 2-bit condition code. It places that code into one of four 2-bit condition fields of a status word and leaves every other bit of the word as it was. The caller supplies the current status word on `status_in`. One cycle after a `start` strobe, `status_out` holds the updated word and `invalid` holds the exception flag for that compare.

There are two variants. The quiet compare treats quiet NaNs as an ordinary unordered outcome and flags `invalid` only when a signalling NaN is present. The signalling compare flags `invalid` on every unordered outcome. The exponent and fraction widths are parameters, and double precision is the default.

Top module: `fp_cc_compare`

## Requirements
- R1: The condition code is 0 when the operands are equal, 1 when `op_a` < `op_b`, and 2 when `op_a` > `op_b`.
- R2: Positive zero and negative zero compare equal (code 0).
- R3: If either operand is a NaN (exponent all ones, fraction nonzero), the code is 3 (unordered).
- R4: With `signalling`=1, `invalid` is 1 exactly when the code is 3.
- R5: With `signalling`=0, `invalid` is 1 only when the code is 3 and at least one operand is a signalling NaN. A signalling NaN has the top fraction bit 0. A quiet NaN alone leaves `invalid` at 0.
- R6: An ordered outcome (code 0, 1 or 2) always leaves `invalid` at 0.
- R7: `fcc_sel` selects where the code is written: 0 writes bits 11:10, 1 writes bits 33:32, 2 writes bits 35:34, and 3 writes bits 37:36.
- R8: Every bit of `status_out` outside the selected field equals the matching bit of `status_in` sampled with `start`.
- R9: `status_out`, `invalid` and `done` update on the clock edge that samples `start`=1. `done` is high for exactly that following cycle. Without `start`, `status_out` and `invalid` hold their values.
- R10: During and after reset, `status_out`, `invalid` and `done` are 0 until the first compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a compare in this cycle |
| signalling | input | 1 | 1 selects the signalling compare, 0 the quiet compare |
| fcc_sel | input | 2 | Selects the condition field to write |
| op_a | input | 1+EXP_W+FRAC_W | First operand |
| op_b | input | 1+EXP_W+FRAC_W | Second operand |
| status_in | input | STAT_W | Current status word |
| status_out | output | STAT_W | Updated status word |
| invalid | output | 1 | Invalid-operation flag of the last compare |
| done | output | 1 | One-cycle pulse when the result is available |

## Verification
The bench builds the block with its default double-precision format (11-bit exponent, 52-bit fraction) and a 64-bit status word. At that format the bench can use the simulator's native real comparison as the reference model: it converts each operand with `$bitstoreal`, so its expected codes do not reuse the sign-magnitude logic of the design. The 64-bit status word contains all four condition fields, including the upper ones at bits 37:32. Random status words check that the bits outside the selected field are preserved. The random operands mix in signed zeros, infinities, identical operands and both kinds of NaN.

// File: rtl/fp_cc_compare.sv
module fp_cc_compare #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int STAT_W = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      signalling,
  input  logic [1:0]                fcc_sel,
  input  logic [EXP_W+FRAC_W:0]     op_a,
  input  logic [EXP_W+FRAC_W:0]     op_b,
  input  logic [STAT_W-1:0]         status_in,
  output logic [STAT_W-1:0]         status_out,
  output logic                      invalid,
  output logic                      done
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam int MAG_W = W - 1;

  logic              sgn_a, sgn_b;
  logic [MAG_W-1:0]  mag_a, mag_b;
  logic              exp1_a, exp1_b, frz_a, frz_b;
  logic              nan_a, nan_b, snan_a, snan_b;
  logic              unord, both_zero, mag_lt, mag_eq;
  logic [1:0]        code;
  logic              inv_d;
  logic [5:0]        lsb;
  logic [STAT_W-1:0] merged;

  assign sgn_a  = op_a[W-1];
  assign sgn_b  = op_b[W-1];
  assign mag_a  = op_a[MAG_W-1:0];
  assign mag_b  = op_b[MAG_W-1:0];
  assign exp1_a = &op_a[W-2:FRAC_W];
  assign exp1_b = &op_b[W-2:FRAC_W];
  assign frz_a  = op_a[FRAC_W-1:0] == '0;
  assign frz_b  = op_b[FRAC_W-1:0] == '0;
  assign nan_a  = exp1_a && !frz_a;
  assign nan_b  = exp1_b && !frz_b;
  assign snan_a = nan_a && !op_a[FRAC_W-1];
  assign snan_b = nan_b && !op_b[FRAC_W-1];

  assign unord     = nan_a || nan_b;
  assign both_zero = (mag_a == '0) && (mag_b == '0);
  assign mag_lt    = mag_a < mag_b;
  assign mag_eq    = mag_a == mag_b;

  always_comb begin
    if (unord)
      code = 2'd3;
    else if (both_zero || (mag_eq && sgn_a == sgn_b))
      code = 2'd0;
    else if (sgn_a != sgn_b)
      code = sgn_a ? 2'd1 : 2'd2;
    else if (!sgn_a)
      code = mag_lt ? 2'd1 : 2'd2;
    else
      code = mag_lt ? 2'd2 : 2'd1;
  end

  assign inv_d = unord && (signalling || snan_a || snan_b);

  assign lsb = (fcc_sel == 2'd0) ? 6'd10 : 6'(30 + 2 * int'(fcc_sel));

  assign merged = (status_in & ~(STAT_W'(3) << lsb)) | (STAT_W'(code) << lsb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_out <= '0;
      invalid    <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        status_out <= merged;
        invalid    <= inv_d;
      end
    end
  end
endmodule

module fp_cc_compare_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int STAT_W = 64
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  signalling,
  input logic [1:0]            fcc_sel,
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic [STAT_W-1:0]     status_in,
  input logic [STAT_W-1:0]     status_out,
  input logic                  invalid,
  input logic                  done
);
  logic [5:0]        pos;
  logic [STAT_W-1:0] fmask;

  always_comb begin
    case (fcc_sel)
      2'd0:    pos = 6'd10;
      2'd1:    pos = 6'd32;
      2'd2:    pos = 6'd34;
      default: pos = 6'd36;
    endcase
    fmask = STAT_W'(3) << pos;
  end

  // R9
  start_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  // R9
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(status_out) && $stable(invalid)));

  // R8
  keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (((status_out ^ $past(status_in)) & ~$past(fmask)) == '0));

  // R4
  sig_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && signalling) |=>
      (invalid == (((status_out >> $past(pos)) & STAT_W'(3)) == STAT_W'(3))));

  // R6
  ord_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!invalid || (((status_out >> $past(pos)) & STAT_W'(3)) == STAT_W'(3))));
endmodule

bind fp_cc_compare fp_cc_compare_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .STAT_W(STAT_W)
) u_chk (.*);

// File: tb/tb_fp_cc_compare.sv
module tb_fp_cc_compare;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        signalling = 1'b0;
  logic [1:0]  fcc_sel = 2'd0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [63:0] status_in = '0;
  logic [63:0] status_out;
  logic        invalid, done;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  fp_cc_compare dut (
    .clk(clk), .rst_n(rst_n), .start(start), .signalling(signalling),
    .fcc_sel(fcc_sel), .op_a(op_a), .op_b(op_b), .status_in(status_in),
    .status_out(status_out), .invalid(invalid), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  localparam logic [63:0] QNAN_P = 64'h7FF8_0000_0000_0001;
  localparam logic [63:0] SNAN_P = 64'h7FF0_0000_0000_0005;
  localparam logic [63:0] INF_P  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NZERO  = 64'h8000_0000_0000_0000;

  function automatic bit is_nan(logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != '0);
  endfunction

  function automatic bit is_snan(logic [63:0] v);
    return is_nan(v) && !v[51];
  endfunction

  function automatic logic [1:0] ref_code(logic [63:0] a, logic [63:0] b);
    real ra, rb;
    if (is_nan(a) || is_nan(b)) return 2'd3;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    if (ra == rb) return 2'd0;
    if (ra < rb)  return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [63:0] ref_status(logic [63:0] st, logic [1:0] sel, logic [1:0] c);
    logic [63:0] r = st;
    case (sel)
      2'd0: r[11:10] = c;
      2'd1: r[33:32] = c;
      2'd2: r[35:34] = c;
      default: r[37:36] = c;
    endcase
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_cmp(logic [63:0] a, logic [63:0] b, bit sig, logic [1:0] sel,
                         logic [63:0] st, string tag);
    logic [1:0]  c;
    logic [63:0] held;
    bit          exp_inv;
    string       itag;
    @(negedge clk);
    op_a = a; op_b = b; signalling = sig; fcc_sel = sel; status_in = st; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c = ref_code(a, b);
    exp_inv = (c == 2'd3) && (sig || is_snan(a) || is_snan(b));
    itag = (c != 2'd3) ? "R6 invalid" : (sig ? "R4 invalid" : "R5 invalid");
    check((c == 2'd3) ? "R3/R7/R8 status" : tag, status_out, ref_status(st, sel, c));
    check(itag, 64'(invalid), 64'(exp_inv));
    check("R9 done pulse", 64'(done), 64'd1);
    held = status_out;
    status_in = ~st; op_a = b; op_b = a; fcc_sel = ~sel;
    @(negedge clk);
    check("R9 hold status", status_out, held);
    check("R9 done low", 64'(done), 64'd0);
  endtask

  function automatic logic [63:0] pick(logic [63:0] other);
    int m = int'($urandom % 9);
    case (m)
      0: return {$urandom, $urandom};
      1: return {$urandom % 2 == 0 ? 1'b0 : 1'b1, 11'h7FF, 1'b1, 51'($urandom)};
      2: return {1'b0, 11'h7FF, 1'b0, 19'($urandom), 32'($urandom) | 32'd1};
      3: return ($urandom % 2) ? NZERO : 64'd0;
      4: return ($urandom % 2) ? (INF_P | NZERO) : INF_P;
      5: return other;
      6: return other ^ NZERO;
      default: return $realtobits(real'(int'($urandom % 41) - 20) / 4.0);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b;
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 2 + 1);
    check("R10 reset status", status_out, 64'd0);
    check("R10 reset invalid", 64'(invalid), 64'd0);
    check("R10 reset done", 64'(done), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 post-reset status", status_out, 64'd0);

    run_cmp($realtobits(1.0), $realtobits(2.0), 0, 2'd0, 64'd0, "R1 less");
    run_cmp($realtobits(2.0), $realtobits(1.0), 0, 2'd1, 64'd0, "R1 greater");
    run_cmp($realtobits(3.5), $realtobits(3.5), 1, 2'd2, '1, "R1 equal");
    run_cmp($realtobits(-1.0), $realtobits(1.0), 0, 2'd3, 64'h0123_4567_89AB_CDEF, "R1 neg<pos");
    run_cmp($realtobits(-2.0), $realtobits(-1.0), 1, 2'd0, '1, "R1 neg mag");
    run_cmp(64'd0, NZERO, 1, 2'd1, '1, "R2 zeros");
    run_cmp(NZERO, 64'd0, 0, 2'd2, 64'd0, "R2 zeros rev");
    run_cmp(QNAN_P, $realtobits(1.0), 0, 2'd0, '1, "R5 qnan quiet");
    run_cmp($realtobits(1.0), SNAN_P, 0, 2'd3, 64'd0, "R5 snan quiet");
    run_cmp(QNAN_P, QNAN_P, 1, 2'd1, 64'd0, "R4 qnan signalling");
    run_cmp(INF_P, $realtobits(1.0e300), 1, 2'd2, '1, "R6 inf ordered");
    for (int s = 0; s < 4; s++)
      run_cmp($realtobits(0.5), $realtobits(0.25), 0, 2'(s), {$urandom, $urandom}, "R7 field");

    for (int i = 0; i < 600; i++) begin
      a = pick(64'd0);
      b = pick(a);
      run_cmp(a, b, 1'($urandom), 2'($urandom), {$urandom, $urandom}, "R1/R7/R8 random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule